// File: doc/BRIEF.md
# CPU-side interrupt acknowledge interface

This block sits between an interrupt distributor and one processor. The distributor presents its single best candidate each cycle (ID, priority and, for software-generated interrupts, the ID of the CPU that raised it). The block holds an enable bit, a priority mask and a binary-point setting. It raises a level interrupt request when that candidate is good enough to interrupt the code now running on the CPU.

Software accepts an interrupt by reading the acknowledge register. That read returns the ID, with the source CPU packed above it, and raises the running priority to the priority of the candidate. The priority it replaced is kept on a small stack of active entries. Software retires the interrupt by writing the same value to the end-of-interrupt register. The top entry is then popped and the previous running priority comes back, so nested interrupts unwind in the correct order. Acknowledge and end-of-interrupt each send a one-cycle strobe with the ID back to the distributor.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, irq_o, ack_o and eoi_o are 0. The enable, priority mask and binary point read back as 0. The running priority reads 0xFF.
- R2: While control bit 0 is clear, irq_o stays 0 and an acknowledge read returns the spurious ID 1023.
- R3: A candidate can be delivered only when its priority is numerically below the priority mask. A mask of 0 blocks everything, and 0xFF passes every priority except 0xFF.
- R4: irq_o is registered. It shows the deliverability of the inputs and state that were present at the previous rising clock edge.
- R5: An acknowledge read of a deliverable candidate returns the ID in bits 9:0. Bits 12:10 carry the source CPU when the ID is below 16 and are 0 otherwise. Higher bits are 0. The running priority becomes the priority of the candidate. ack_o pulses for one cycle with ack_id_o equal to the ID.
- R6: When nothing is deliverable, an acknowledge read returns 1023 and does not change any state. Candidate IDs of 1022 and above are never delivered.
- R7: While an interrupt is active, a candidate can preempt only if its group priority is lower than the group priority of the running priority. The group priority is the priority with its low (binary point + 1) bits cleared. A binary point of 7 blocks all preemption.
- R8: An end-of-interrupt write is compared on bits 9:0 only. When those bits match the most recently acknowledged active ID, that entry is popped and the running priority returns to its previous value (0xFF when the stack empties). eoi_o pulses for one cycle with eoi_id_o equal to that ID.
- R9: An end-of-interrupt write whose ID does not match the top active entry, or that arrives with no active entry, is ignored. No strobe is produced and the running priority does not change.
- R10: At most 4 interrupts can be active at once. With 4 active, irq_o stays 0 and an acknowledge read returns 1023.
- R11: Register map on reg_addr_i: 0 = enable (bit 0), 1 = priority mask (bits 7:0), 2 = binary point (bits 2:0), 3 = acknowledge (read), 4 = end-of-interrupt (write), 5 = running priority (read), 6 = highest pending. Highest pending reads as {source, ID} packed as in R5, or 1023 when no candidate is valid. Read data appears on reg_rdata_o after the edge that samples reg_re_i. All other addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| cand_valid_i | input | 1 | Distributor candidate present |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| cand_src_i | input | 3 | Source CPU of a software-generated candidate |
| irq_o | output | 1 | Interrupt request to the CPU |
| ack_o | output | 1 | Acknowledge strobe to the distributor |
| ack_id_o | output | 10 | ID acknowledged |
| eoi_o | output | 1 | End-of-interrupt strobe to the distributor |
| eoi_id_o | output | 10 | ID retired |

## Verification
Each register access is applied for exactly one rising edge. The bench samples read data, ack_o and eoi_o at the falling edge that follows, because all three are registered at that same edge. irq_o lags its inputs and state by one edge. After any candidate or mask change the bench therefore advances one idle cycle before it samples. After an acknowledge or end-of-interrupt it also waits one idle cycle, so that the new running priority is visible on irq_o. The R4 check samples irq_o once before and once after the edge to confirm this lag.

// File: rtl/cpu_iface_pkg.sv
package cpu_iface_pkg;
  localparam int ID_W      = 10;
  localparam int SRC_W     = 3;
  localparam int PRIO_W    = 8;
  localparam int BP_W      = $clog2(PRIO_W);
  localparam int DATA_W    = 32;
  localparam int SGI_COUNT = 16;

  localparam logic [ID_W-1:0] SPURIOUS_ID = ID_W'(1023);
  localparam logic [ID_W-1:0] FIRST_RSVD  = ID_W'(1022);

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic [ID_W-1:0] id;
    prio_t           prio;
  } active_t;

  typedef enum logic [2:0] {
    ADDR_CTL  = 3'd0,
    ADDR_PMR  = 3'd1,
    ADDR_BP   = 3'd2,
    ADDR_ACK  = 3'd3,
    ADDR_EOI  = 3'd4,
    ADDR_RUN  = 3'd5,
    ADDR_HPND = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/cpu_iface_prio_cmp.sv
module cpu_iface_prio_cmp
  import cpu_iface_pkg::*;
(
  input  logic            en_i,
  input  logic            cand_valid_i,
  input  logic [ID_W-1:0] cand_id_i,
  input  prio_t           cand_prio_i,
  input  prio_t           prio_mask_i,
  input  logic [BP_W-1:0] bp_i,
  input  logic            busy_i,
  input  logic            full_i,
  input  prio_t           run_prio_i,
  output logic            deliver_o
);
  logic [PRIO_W:0] span;
  logic [PRIO_W:0] span_m1;
  prio_t           grp_mask;
  logic            pass_mask;
  logic            pass_group;
  logic            unused_span;

  // group part = priority with low (bp+1) bits cleared
  assign span        = (PRIO_W+1)'(2) << bp_i;
  assign span_m1     = span - (PRIO_W+1)'(1);
  assign grp_mask    = ~span_m1[PRIO_W-1:0];
  assign unused_span = span_m1[PRIO_W];

  assign pass_mask  = cand_prio_i < prio_mask_i;
  assign pass_group = !busy_i || ((cand_prio_i & grp_mask) < (run_prio_i & grp_mask));

  assign deliver_o = en_i && cand_valid_i && (cand_id_i < FIRST_RSVD) &&
                     pass_mask && pass_group && !full_i;
endmodule

// File: rtl/cpu_iface_active_stack.sv
module cpu_iface_active_stack
  import cpu_iface_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    push_i,
  input  active_t push_entry_i,
  input  logic    pop_i,
  output active_t top_o,
  output logic    empty_o,
  output logic    full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  active_t          stk_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_idx;
  logic             unused_idx;

  assign empty_o    = cnt_q == '0;
  assign full_o     = cnt_q == CNT_W'(DEPTH);
  assign top_idx    = cnt_q - CNT_W'(1);
  assign unused_idx = ^top_idx[CNT_W-1:IDX_W];
  assign top_o      = empty_o ? '0 : stk_q[top_idx[IDX_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stk_q[g] <= '0;
      end else if (push_i && !full_o && cnt_q == CNT_W'(g)) begin
        stk_q[g] <= push_entry_i;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o) else $error("push on full stack"); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o) else $error("pop on empty stack"); // R9
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cpu_iface_pkg::*;
#(
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [SRC_W-1:0]  cand_src_i,
  output logic              irq_o,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  localparam int PACK_W = ID_W + SRC_W;

  logic            ctl_en_q;
  prio_t           pmr_q;
  logic [BP_W-1:0] bp_q;
  logic            deliver;
  logic            rd_ack, ack_fire, eoi_fire;
  active_t         top;
  logic            empty, full;
  prio_t           run_prio;
  logic [SRC_W-1:0]  src_field;
  logic [PACK_W-1:0] cand_pack;
  logic [DATA_W-1:0] rdata_d;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:ID_W];
  assign run_prio     = empty ? '1 : top.prio;
  assign src_field    = (cand_id_i < ID_W'(SGI_COUNT)) ? cand_src_i : '0;
  assign cand_pack    = {src_field, cand_id_i};

  assign rd_ack   = reg_re_i && reg_addr_i == ADDR_ACK;
  assign ack_fire = rd_ack && deliver;
  assign eoi_fire = reg_we_i && reg_addr_i == ADDR_EOI && !empty &&
                    reg_wdata_i[ID_W-1:0] == top.id;

  cpu_iface_prio_cmp u_cmp (
    .en_i        (ctl_en_q),
    .cand_valid_i(cand_valid_i),
    .cand_id_i   (cand_id_i),
    .cand_prio_i (cand_prio_i),
    .prio_mask_i (pmr_q),
    .bp_i        (bp_q),
    .busy_i      (!empty),
    .full_i      (full),
    .run_prio_i  (run_prio),
    .deliver_o   (deliver)
  );

  cpu_iface_active_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ack_fire),
    .push_entry_i('{id: cand_id_i, prio: cand_prio_i}),
    .pop_i       (eoi_fire),
    .top_o       (top),
    .empty_o     (empty),
    .full_o      (full)
  );

  always_comb begin
    rdata_d = '0;
    case (reg_addr_i)
      ADDR_CTL:  rdata_d = DATA_W'(ctl_en_q);
      ADDR_PMR:  rdata_d = DATA_W'(pmr_q);
      ADDR_BP:   rdata_d = DATA_W'(bp_q);
      ADDR_ACK:  rdata_d = deliver ? DATA_W'(cand_pack) : DATA_W'(SPURIOUS_ID);
      ADDR_RUN:  rdata_d = DATA_W'(run_prio);
      ADDR_HPND: rdata_d = cand_valid_i ? DATA_W'(cand_pack) : DATA_W'(SPURIOUS_ID);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_en_q <= 1'b0;
      pmr_q    <= '0;
      bp_q     <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        ADDR_CTL: ctl_en_q <= reg_wdata_i[0];
        ADDR_PMR: pmr_q    <= reg_wdata_i[PRIO_W-1:0];
        ADDR_BP:  bp_q     <= reg_wdata_i[BP_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o <= '0;
      irq_o       <= 1'b0;
      ack_o       <= 1'b0;
      ack_id_o    <= '0;
      eoi_o       <= 1'b0;
      eoi_id_o    <= '0;
    end else begin
      irq_o <= deliver;
      ack_o <= ack_fire;
      eoi_o <= eoi_fire;
      if (reg_re_i) reg_rdata_o <= rdata_d;
      if (ack_fire) ack_id_o <= cand_id_i;
      if (eoi_fire) eoi_id_o <= top.id;
    end
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ctl_en_q)) else $error("irq while disabled"); // R2
  AST_IRQ_UNDER_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(cand_prio_i) < $past(pmr_q)) else $error("irq above mask"); // R3
  AST_ACK_SETS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> run_prio == $past(cand_prio_i)) else $error("running prio not taken"); // R5
  AST_ACK_NOT_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_id_o < FIRST_RSVD) else $error("reserved id acknowledged"); // R6
  AST_EOI_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> eoi_id_o == $past(reg_wdata_i[ID_W-1:0])) else $error("eoi id mismatch"); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && eoi_o)) else $error("ack and eoi together"); // R8
endmodule

// File: tb/cpu_irq_iface_tb.sv
module cpu_irq_iface_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic [2:0]  cand_src = '0;
  logic        irq, ack, eoi;
  logic [9:0]  ack_id, eoi_id;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpu_irq_iface u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cand_valid_i(cand_valid), .cand_id_i(cand_id), .cand_prio_i(cand_prio),
    .cand_src_i(cand_src), .irq_o(irq), .ack_o(ack), .ack_id_o(ack_id),
    .eoi_o(eoi), .eoi_id_o(eoi_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_re = 1'b1; reg_addr = a;
    cyc();
    d = reg_rdata;
    reg_re = 1'b0;
  endtask

  task automatic cand(input logic v, input logic [9:0] id, input logic [7:0] p, input logic [2:0] s);
    cand_valid = v; cand_id = id; cand_prio = p; cand_src = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 ack", 32'(ack), 0);
    check("R1 eoi", 32'(eoi), 0);
    rd(3'd0, d); check("R1 ctl", d, 0);
    rd(3'd1, d); check("R1 pmr", d, 0);
    rd(3'd2, d); check("R1 bp", d, 0);
    rd(3'd5, d); check("R1 run", d, 32'hFF);

    // R3 mask sweep, idle
    wr(3'd0, 1);
    foreach (pmr_list[i]) ;
    for (int m = 0; m < 4; m++) begin
      int pm;
      pm = (m == 0) ? 0 : (m == 1) ? 8'h10 : (m == 2) ? 8'h80 : 8'hFF;
      wr(3'd1, 32'(pm));
      for (int p = 0; p < 256; p += 15) begin
        cand(1'b1, 10'd40, 8'(p), 3'd0);
        cyc();
        check("R3 mask", 32'(irq), 32'(p < pm));
      end
    end

    // R4 one-cycle lag
    cand(1'b1, 10'd40, 8'h00, 3'd0);
    cyc();
    cand(1'b0, 10'd40, 8'h00, 3'd0);
    #1 check("R4 before edge", 32'(irq), 1);
    cyc();
    check("R4 after edge", 32'(irq), 0);

    // R2 disable
    cand(1'b1, 10'd40, 8'h10, 3'd0);
    wr(3'd0, 0);
    cyc();
    check("R2 irq off", 32'(irq), 0);
    rd(3'd3, d); check("R2 ack spurious", d, 1023);
    rd(3'd5, d); check("R2 run unchanged", d, 32'hFF);
    wr(3'd0, 1);

    // R6 reserved ids
    cand(1'b1, 10'd1022, 8'h00, 3'd0);
    cyc();
    check("R6 rsvd irq", 32'(irq), 0);
    rd(3'd3, d); check("R6 rsvd ack", d, 1023);
    check("R6 no ack strobe", 32'(ack), 0);
    rd(3'd5, d); check("R6 run unchanged", d, 32'hFF);
    cand(1'b1, 10'd1021, 8'h00, 3'd0);
    cyc();
    check("R6 1021 deliverable", 32'(irq), 1);

    // R5/R11 SGI packing
    cand(1'b1, 10'd5, 8'h40, 3'd3);
    rd(3'd6, d); check("R11 hpend", d, 32'hC05);
    rd(3'd3, d); check("R5 ack sgi", d, 32'hC05);
    check("R5 ack strobe", 32'(ack), 1);
    check("R5 ack id", 32'(ack_id), 5);
    rd(3'd5, d); check("R5 run", d, 32'h40);
    check("R5 strobe one cycle", 32'(ack), 0);
    wr(3'd4, 32'hC05);
    check("R8 eoi strobe", 32'(eoi), 1);
    check("R8 eoi id", 32'(eoi_id), 5);
    rd(3'd5, d); check("R8 run idle", d, 32'hFF);
    cand(1'b1, 10'd100, 8'h40, 3'd3);
    rd(3'd3, d); check("R5 ack non-sgi", d, 100);
    wr(3'd4, 100);
    check("R8 eoi 100", 32'(eoi), 1);
    cand(1'b0, 10'd0, 8'h00, 3'd0);
    rd(3'd6, d); check("R11 hpend empty", d, 1023);
    rd(3'd7, d); check("R11 unmapped", d, 0);

    // R7 binary point sweep
    for (int bp = 0; bp < 8; bp++) begin
      wr(3'd2, 32'(bp));
      cand(1'b1, 10'd40, 8'h80, 3'd0);
      rd(3'd3, d); check("R7 ack base", d, 40);
      for (int p = 0; p < 256; p += 16) begin
        cand(1'b1, 10'd41, 8'(p), 3'd0);
        cyc();
        check($sformatf("R7 bp%0d p%0h", bp, p), 32'(irq),
              32'((p >> (bp + 1)) < (128 >> (bp + 1))));
      end
      wr(3'd4, 40);
      check("R7 eoi", 32'(eoi), 1);
    end

    // R10 nesting depth, R9 mismatch, R8 unwind
    wr(3'd2, 0);
    for (int k = 0; k < 4; k++) begin
      cand(1'b1, 10'(50 + k), 8'(8'h80 - 8'h20 * k), 3'd0);
      cyc();
      check("R7 nest irq", 32'(irq), 1);
      rd(3'd3, d); check("R5 nest ack", d, 32'(50 + k));
    end
    cand(1'b1, 10'd60, 8'h00, 3'd0);
    cyc(); cyc();
    check("R10 full irq", 32'(irq), 0);
    rd(3'd3, d); check("R10 full ack", d, 1023);
    cand(1'b0, 10'd0, 8'h00, 3'd0);
    wr(3'd4, 50);
    check("R9 mismatch no strobe", 32'(eoi), 0);
    rd(3'd5, d); check("R9 run kept", d, 32'h20);
    for (int k = 3; k >= 0; k--) begin
      wr(3'd4, 32'(50 + k));
      check("R8 unwind strobe", 32'(eoi), 1);
      check("R8 unwind id", 32'(eoi_id), 32'(50 + k));
      rd(3'd5, d);
      check("R8 unwind run", d, (k == 0) ? 32'hFF : 32'(8'h80 - 8'h20 * (k - 1)));
    end
    wr(3'd4, 50);
    check("R9 empty no strobe", 32'(eoi), 0);
    rd(3'd5, d); check("R9 empty run", d, 32'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int pmr_list[1];
endmodule